// File: doc/BRIEF.md
# I2C Multi-Segment Transaction Master

This block is an I2C bus master that carries out a group of message segments as one bus transaction. Software-side logic hands it one segment descriptor at a time: a target address (7 or 10 bits), a 16-bit flag word, a byte count and a marker saying whether this is the final segment of the group. The master opens each segment with a START condition. A segment that follows another in the same group opens with a repeated START, because no STOP is placed between them. It then sends the address with the direction bit, moves the data bytes, and reports a status code and a byte count when the segment ends.

Write data is taken from a transmit stream, which pulses a take strobe once per byte. Read data leaves on a receive stream with a one-cycle valid strobe. SCL and SDA are open-drain lines. Each is modelled as an output-enable (1 pulls the line low) and a line input. A target that holds SCL low stretches the clock, and the master waits for as long as the line stays low. Several flags change the segment's behaviour: a ten-bit address mode, a receive-length mode in which the first byte read gives the count of further bytes, and an ignore-NAK mode that stops a target NAK from ending the segment.

Top module: `i2c_seg_master`

## Requirements
- R1: Every segment opens with a START condition (SDA falls while SCL is high). A segment accepted after a non-final segment opens with a repeated START, with no STOP between the two segments.
- R2: In 7-bit mode the first byte after START is {addr[6:0], dir}, sent MSB first. dir is 1 for a read and 0 for a write, and reads are selected by flags bit 0.
- R3: When flags bit 4 is set, the address goes out as two bytes: {5'b11110, addr[9:8], dir}, then addr[7:0].
- R4: A write segment sends seg_len bytes from tx_data, MSB first, with one tx_take pulse for each byte consumed. A clean finish reports status 0 and a count equal to seg_len.
- R5: A read segment delivers each received byte on rx_data with a one-cycle rx_valid pulse. The master ACKs every byte except the last and NAKs the last.
- R6: A NAK on an address byte ends the segment with status 1 and count 0, followed by a STOP.
- R7: A target NAK on a written data byte ends the segment with status 2, followed by a STOP. The count includes the NAKed byte.
- R8: With flags bit 12 set, a target NAK does not end the segment. All bytes are moved and the status is 0.
- R9: With flags bit 10 set on a read, the first byte received is ACKed and gives the number of further bytes to read, capped at 32. seg_len is ignored, and the reported count includes the count byte.
- R10: A STOP condition (SDA rises while SCL is high) is produced only after a segment marked last, or after a segment that ends on a NAK.
- R11: While the master has released SCL and SCL reads low, the bit timing waits. A stretched transfer still completes with correct data.
- R12: After reset both lines are released, seg_ready is 1 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid | input | 1 | Segment descriptor present |
| seg_ready | output | 1 | Master idle, descriptor accepted when valid |
| seg_addr | input | 10 | Target address |
| seg_flags | input | 16 | Bit 0 read, bit 4 ten-bit, bit 10 receive-length, bit 12 ignore NAK |
| seg_len | input | 8 | Data byte count |
| seg_last | input | 1 | Final segment of the group |
| tx_data | input | 8 | Next byte to write |
| tx_take | output | 1 | tx_data consumed this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data valid for one cycle |
| done | output | 1 | Segment finished, one-cycle pulse |
| done_status | output | 2 | 0 success, 1 address NAK, 2 data NAK |
| done_count | output | 8 | Data bytes moved in the segment |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
Each bus bit takes four quarter-periods of QTR cycles each, plus a few handshake cycles between bits and any time SCL is stretched. A bus-level result therefore has no fixed latency. The bench does not count a fixed number of cycles after a descriptor is accepted. It samples on every falling clock edge and waits for the one-cycle done pulse, reading done_status and done_count in that same cycle. rx_valid and tx_take are collected on every falling edge as they occur, and a bus-watching target model logs START/STOP conditions, address bytes, write data and the master's ACK bits as they happen on the lines, so every check compares logged bus events against values worked out from the requirements.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    parameter int CNT_W  = 8;
    parameter int ADDR_W = 10;
    parameter int FLAG_W = 16;

    localparam int FB_READ = 0;
    localparam int FB_TEN  = 4;
    localparam int FB_RLEN = 10;
    localparam int FB_IGN  = 12;

    typedef enum logic [1:0] {PC_START, PC_STOP, PC_BIT} bit_cmd_e;
    typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_XFER} byte_op_e;
    typedef enum logic [1:0] {ST_OK = 2'd0, ST_ADDR_NAK = 2'd1, ST_DATA_NAK = 2'd2} status_e;
    typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR1, S_ADDR2, S_DATA, S_STOP, S_DONE} seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [FLAG_W-1:0] flags;
        logic [CNT_W-1:0]  len;
        logic              last;
    } seg_desc_t;

    function automatic logic [CNT_W-1:0] clamp_len(input logic [7:0] b, input int unsigned lim);
        if (32'(b) > lim) return CNT_W'(lim);
        return CNT_W'(b);
    endfunction
endpackage

// File: rtl/i2cm_bitphy.sv
module i2cm_bitphy import i2cm_pkg::*; #(
    parameter int QTR = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  bit_cmd_e cmd,
    input  logic     bit_w,
    output logic     done,
    output logic     bit_r,
    output logic     scl_oe,
    output logic     sda_oe,
    input  logic     scl_in,
    input  logic     sda_in
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

    logic          busy;
    bit_cmd_e      cmd_r;
    logic          b_r;
    logic [1:0]    ph;
    logic [CW-1:0] cnt;
    logic          want_scl_low, want_sda_low;

    always_comb begin
        unique case (cmd_r)
            PC_START: begin want_scl_low = (ph == 2'd0) || (ph == 2'd3); want_sda_low = ph[1];  end
            PC_STOP:  begin want_scl_low = (ph == 2'd0);                 want_sda_low = !ph[1]; end
            default:  begin want_scl_low = (ph == 2'd0) || (ph == 2'd3); want_sda_low = !b_r;   end
        endcase
    end

    wire stall     = !want_scl_low && !scl_in;
    wire last_tick = (cnt == CW'(QTR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; cmd_r <= PC_BIT; b_r <= 1'b1; ph <= 2'd0; cnt <= '0;
            done <= 1'b0; bit_r <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (cmd_valid) begin
                    busy <= 1'b1; cmd_r <= cmd; b_r <= bit_w; ph <= 2'd0; cnt <= '0;
                end
            end else begin
                scl_oe <= want_scl_low;
                sda_oe <= want_sda_low;
                if (!stall) begin
                    if (last_tick) begin
                        cnt <= '0;
                        if (ph == 2'd2) bit_r <= sda_in;
                        if (ph == 2'd3) begin busy <= 1'b0; done <= 1'b1; end
                        ph <= ph + 2'd1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
            end
        end
    end

    // R11: a low SCL while released freezes the bit timing
    assert_stretch_wait_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !want_scl_low && !scl_in && scl_oe == want_scl_low) |=> ($stable(ph) && $stable(cnt)));
endmodule

// File: rtl/i2cm_byteeng.sv
module i2cm_byteeng import i2cm_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  byte_op_e op,
    input  logic [7:0] tx_byte,
    input  logic     ack_w,
    output logic     done,
    output logic [7:0] rx_byte,
    output logic     ack_r,
    output logic     p_valid,
    output bit_cmd_e p_cmd,
    output logic     p_bit,
    input  logic     p_done,
    input  logic     p_bit_r
);
    logic       busy;
    byte_op_e   op_r;
    logic [7:0] sh;
    logic [3:0] idx;
    logic       ackw_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; op_r <= BOP_XFER; sh <= '1; idx <= '0; ackw_r <= 1'b1;
            done <= 1'b0; rx_byte <= '0; ack_r <= 1'b1;
            p_valid <= 1'b0; p_cmd <= PC_BIT; p_bit <= 1'b1;
        end else begin
            done    <= 1'b0;
            p_valid <= 1'b0;
            if (go && !busy) begin
                busy <= 1'b1; op_r <= op; sh <= {tx_byte[6:0], 1'b1};
                ackw_r <= ack_w; idx <= '0; p_valid <= 1'b1; p_bit <= tx_byte[7];
                p_cmd <= (op == BOP_START) ? PC_START : (op == BOP_STOP) ? PC_STOP : PC_BIT;
            end else if (busy && p_done) begin
                if (op_r != BOP_XFER || idx == 4'd8) begin
                    busy <= 1'b0; done <= 1'b1;
                    if (op_r == BOP_XFER) ack_r <= p_bit_r;
                end else begin
                    rx_byte <= {rx_byte[6:0], p_bit_r};
                    idx     <= idx + 4'd1;
                    p_valid <= 1'b1;
                    p_cmd   <= PC_BIT;
                    p_bit   <= (idx == 4'd7) ? ackw_r : sh[7];
                    sh      <= {sh[6:0], 1'b1};
                end
            end
        end
    end

    // R4: the bit layer only finishes work this engine handed it
    assert_bit_in_step_R4: assert property (@(posedge clk) disable iff (rst)
        p_done |-> busy);
endmodule

// File: rtl/i2c_seg_master.sv
module i2c_seg_master import i2cm_pkg::*; #(
    parameter int QTR    = 4,
    parameter int MAX_RX = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [FLAG_W-1:0] seg_flags,
    input  logic [CNT_W-1:0]  seg_len,
    input  logic              seg_last,
    input  logic [7:0]        tx_data,
    output logic              tx_take,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              done,
    output logic [1:0]        done_status,
    output logic [CNT_W-1:0]  done_count,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              scl_in,
    input  logic              sda_in
);
    seq_state_e       st;
    seg_desc_t        seg;
    logic             lenph;
    logic [CNT_W-1:0] rem, cnt;
    status_e          stat;

    logic       b_go, b_ack, b_done, b_nak;
    byte_op_e   b_op;
    logic [7:0] b_tx, b_rx;
    logic       p_valid, p_bit, p_done, p_bit_r;
    bit_cmd_e   p_cmd;

    i2cm_byteeng u_byte (
        .clk, .rst, .go(b_go), .op(b_op), .tx_byte(b_tx), .ack_w(b_ack),
        .done(b_done), .rx_byte(b_rx), .ack_r(b_nak),
        .p_valid, .p_cmd, .p_bit, .p_done, .p_bit_r
    );

    i2cm_bitphy #(.QTR(QTR)) u_phy (
        .clk, .rst, .cmd_valid(p_valid), .cmd(p_cmd), .bit_w(p_bit),
        .done(p_done), .bit_r(p_bit_r), .scl_oe, .sda_oe, .scl_in, .sda_in
    );

    wire is_rd  = seg.flags[FB_READ];
    wire is_ten = seg.flags[FB_TEN];
    wire is_ign = seg.flags[FB_IGN];
    wire in_xfr = (st == S_ADDR1) || (st == S_ADDR2) || (st == S_DATA);

    logic [CNT_W-1:0] rem_use;
    logic             lp_use, abort_now, proceed, data_now, fin_now, ten_now, nak_next;

    always_comb begin
        rem_use   = (st == S_DATA) ? (lenph ? clamp_len(b_rx, MAX_RX) : rem - CNT_W'(1)) : rem;
        lp_use    = (st == S_DATA) ? 1'b0 : lenph;
        nak_next  = (rem_use == CNT_W'(1)) && !lp_use;
        abort_now = in_xfr && b_done && b_nak && !is_ign && !(st == S_DATA && is_rd);
        proceed   = b_done && ((st == S_ADDR2) || (st == S_DATA) || (st == S_ADDR1 && !is_ten));
        ten_now   = (st == S_ADDR1) && b_done && is_ten && !abort_now;
        data_now  = proceed && !abort_now && (rem_use != '0);
        fin_now   = abort_now || (proceed && rem_use == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; seg <= '0; lenph <= 1'b0; rem <= '0; cnt <= '0; stat <= ST_OK;
            b_go <= 1'b0; b_op <= BOP_START; b_tx <= '1; b_ack <= 1'b1;
            tx_take <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
        end else begin
            b_go <= 1'b0; tx_take <= 1'b0; rx_valid <= 1'b0;
            unique case (st)
                S_IDLE: if (seg_valid) begin
                    seg   <= '{addr: seg_addr, flags: seg_flags, len: seg_len, last: seg_last};
                    lenph <= seg_flags[FB_READ] && seg_flags[FB_RLEN];
                    rem   <= (seg_flags[FB_READ] && seg_flags[FB_RLEN]) ? CNT_W'(1) : seg_len;
                    cnt   <= '0; stat <= ST_OK;
                    b_go  <= 1'b1; b_op <= BOP_START; st <= S_START;
                end
                S_START: if (b_done) begin
                    b_go <= 1'b1; b_op <= BOP_XFER; b_ack <= 1'b1; st <= S_ADDR1;
                    b_tx <= is_ten ? {5'b11110, seg.addr[9:8], is_rd} : {seg.addr[6:0], is_rd};
                end
                S_STOP: if (b_done) st <= S_DONE;
                S_DONE: st <= S_IDLE;
                default: ;
            endcase
            if (st == S_DATA && b_done) begin
                cnt      <= cnt + CNT_W'(1);
                rem      <= rem_use;
                lenph    <= 1'b0;
                rx_valid <= is_rd;
                rx_data  <= b_rx;
            end
            if (ten_now) begin
                b_go <= 1'b1; b_op <= BOP_XFER; b_ack <= 1'b1; b_tx <= seg.addr[7:0]; st <= S_ADDR2;
            end
            if (data_now) begin
                b_go    <= 1'b1; b_op <= BOP_XFER; st <= S_DATA;
                b_tx    <= is_rd ? 8'hFF : tx_data;
                b_ack   <= is_rd ? nak_next : 1'b1;
                tx_take <= !is_rd;
            end
            if (fin_now) begin
                if (abort_now) stat <= (st == S_DATA) ? ST_DATA_NAK : ST_ADDR_NAK;
                if (abort_now || seg.last) begin
                    b_go <= 1'b1; b_op <= BOP_STOP; st <= S_STOP;
                end else begin
                    st <= S_DONE;
                end
            end
        end
    end

    assign seg_ready   = (st == S_IDLE);
    assign done        = (st == S_DONE);
    assign done_status = stat;
    assign done_count  = cnt;

    // R10: a STOP seen on the lines belongs to the stop step
    assert_stop_only_end_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_in) && scl_in && $past(scl_in)) |-> (st == S_STOP));
    // R10: finishing without a STOP is only for a clean non-final segment
    assert_no_stop_means_chain_R10: assert property (@(posedge clk) disable iff (rst)
        (st == S_DONE && $past(st) != S_STOP) |-> (!seg.last && stat == ST_OK));
    // R5: received bytes only appear in read segments
    assert_rx_in_read_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> is_rd);
    // R4: transmit bytes are only consumed in write segments
    assert_tx_in_write_R4: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> !is_rd);
endmodule

// File: tb/tb_i2c_seg_master.sv
`timescale 1ns/1ps
module tb_i2c_seg_master;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       seg_valid = 1'b0;
    logic [9:0] seg_addr = '0;
    logic [15:0] seg_flags = '0;
    logic [7:0] seg_len = '0;
    logic       seg_last = 1'b0;
    logic       seg_ready, tx_take, rx_valid, done, scl_oe, sda_oe;
    logic [7:0] rx_data, done_count, tx_data;
    logic [1:0] done_status;

    logic sl_sda_low = 1'b0;
    int   hold = 0;
    wire  sl_scl_low = (hold > 0);
    wire  scl_bus = !(scl_oe || sl_scl_low);
    wire  sda_bus = !(sda_oe || sl_sda_low);

    logic [7:0] tx_arr [8];
    int   tx_i = 0;
    assign tx_data = tx_arr[tx_i[2:0]];

    i2c_seg_master dut (
        .clk, .rst, .seg_valid, .seg_ready, .seg_addr, .seg_flags, .seg_len, .seg_last,
        .tx_data, .tx_take, .rx_data, .rx_valid, .done, .done_status, .done_count,
        .scl_oe, .sda_oe, .scl_in(scl_bus), .sda_in(sda_bus)
    );

    int n_checks = 0, n_fail = 0;
    logic clr = 1'b0;

    // target model settings
    localparam logic [6:0] SL7  = 7'h52;
    localparam logic [9:0] SL10 = 10'h2A5;
    int nak_at = 0, stretch = 0;
    logic len_en = 1'b0;
    logic [7:0] len_val = 8'd0, rd_base = 8'h40;

    // target model logs
    logic [7:0] ev_log [16];  int n_ev;
    logic [7:0] addr_log [8]; int n_addr;
    logic [7:0] wr_log [64];  int n_wr;
    logic       mack_log [64]; int n_mack;
    int low_run, low_max;

    logic pscl, psda, dirrd, acked, mack, ackv;
    int mode, bitc, rd_i;
    logic [7:0] sh, cur;

    function automatic logic [7:0] src_byte(input int i);
        return (i == 0 && len_en) ? len_val : 8'(rd_base + 8'(i));
    endfunction

    always @(posedge clk) begin
        if (rst || clr) begin
            pscl <= 1'b1; psda <= 1'b1; mode <= 0; bitc <= 0; sl_sda_low <= 1'b0; hold <= 0;
            n_ev <= 0; n_addr <= 0; n_wr <= 0; n_mack <= 0; rd_i <= 0; low_run <= 0; low_max <= 0;
            acked <= 1'b0; dirrd <= 1'b0; mack <= 1'b1; sh <= '0; cur <= '0;
        end else begin
            pscl <= scl_bus; psda <= sda_bus;
            if (hold > 0) hold <= hold - 1;
            low_run <= scl_bus ? 0 : low_run + 1;
            if (!scl_bus && low_run + 1 > low_max) low_max <= low_run + 1;
            if (pscl && scl_bus && psda && !sda_bus) begin
                if (n_ev < 16) ev_log[n_ev] <= "S";
                n_ev <= n_ev + 1; mode <= 1; bitc <= 0; rd_i <= 0; sl_sda_low <= 1'b0;
            end else if (pscl && scl_bus && !psda && sda_bus) begin
                if (n_ev < 16) ev_log[n_ev] <= "P";
                n_ev <= n_ev + 1; mode <= 0; bitc <= 0; sl_sda_low <= 1'b0;
            end else if (mode != 0 && !pscl && scl_bus) begin
                if (bitc < 8 && mode != 4) sh <= {sh[6:0], sda_bus};
                if (bitc == 8 && mode == 4) begin
                    mack <= sda_bus;
                    if (n_mack < 64) mack_log[n_mack] <= sda_bus;
                    n_mack <= n_mack + 1;
                end
                bitc <= bitc + 1;
            end else if (mode != 0 && pscl && !scl_bus) begin
                if (stretch > 0) hold <= stretch;
                if (bitc == 8) begin
                    if (mode == 4) sl_sda_low <= 1'b0;
                    else begin
                        if (mode == 1) begin
                            if (n_addr < 8) addr_log[n_addr] <= sh;
                            n_addr <= n_addr + 1; dirrd <= sh[0];
                            ackv = (sh[7:3] == 5'b11110) ? (sh[2:1] == SL10[9:8]) : (sh[7:1] == SL7);
                        end else if (mode == 2) begin
                            if (n_addr < 8) addr_log[n_addr] <= sh;
                            n_addr <= n_addr + 1;
                            ackv = (sh == SL10[7:0]);
                        end else begin
                            if (n_wr < 64) wr_log[n_wr] <= sh;
                            n_wr <= n_wr + 1;
                            ackv = (n_wr + 1 != nak_at);
                        end
                        sl_sda_low <= ackv; acked <= ackv;
                    end
                end else if (bitc == 9) begin
                    bitc <= 0; sl_sda_low <= 1'b0;
                    if (mode == 1 || mode == 2) begin
                        if (!acked) mode <= 0;
                        else if (mode == 1 && sh[7:3] == 5'b11110) mode <= 2;
                        else if (dirrd) begin
                            mode <= 4; cur <= src_byte(0); rd_i <= 1; sl_sda_low <= !src_byte(0)[7];
                        end else mode <= 3;
                    end else if (mode == 4) begin
                        if (!mack) begin
                            cur <= src_byte(rd_i); rd_i <= rd_i + 1; sl_sda_low <= !src_byte(rd_i)[7];
                        end else mode <= 0;
                    end
                end else if (mode == 4 && bitc >= 1 && bitc <= 7) begin
                    sl_sda_low <= !cur[7 - bitc];
                end
            end
        end
    end

    logic [7:0] rx_mem [64];
    int rx_n = 0, take_n = 0;
    always @(negedge clk) begin
        if (clr) begin
            rx_n = 0; take_n = 0; tx_i = 0;
        end else begin
            if (rx_valid) begin
                if (rx_n < 64) rx_mem[rx_n] = rx_data;
                rx_n++;
            end
            if (tx_take) begin tx_i++; take_n++; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        clr = 1'b1;
        repeat (2) @(posedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_seg(input logic [9:0] a, input logic [15:0] f, input logic [7:0] n, input logic lst);
        @(negedge clk);
        while (!seg_ready) @(negedge clk);
        seg_addr = a; seg_flags = f; seg_len = n; seg_last = lst; seg_valid = 1'b1;
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    task automatic wait_done(output int st, output int cnt);
        do @(negedge clk); while (!done);
        st = done_status; cnt = done_count;
    endtask

    task automatic t_reset();
        chk("R12", "scl_oe", scl_oe, 0);
        chk("R12", "sda_oe", sda_oe, 0);
        chk("R12", "seg_ready", seg_ready, 1);
        chk("R12", "done", done, 0);
    endtask

    task automatic t_write7();
        int st, cnt;
        clear_all();
        tx_arr[0] = 8'h11; tx_arr[1] = 8'h22; tx_arr[2] = 8'h3C;
        send_seg(10'h052, 16'h0000, 8'd3, 1'b1);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        chk("R2", "addr byte", addr_log[0], 8'hA4);
        chk("R4", "status", st, 0);
        chk("R4", "count", cnt, 3);
        chk("R4", "take pulses", take_n, 3);
        chk("R4", "byte0", wr_log[0], 8'h11);
        chk("R4", "byte2", wr_log[2], 8'h3C);
        chk("R1", "first event START", ev_log[0], "S");
        chk("R10", "events", n_ev, 2);
        chk("R10", "STOP last", ev_log[1], "P");
    endtask

    task automatic t_read7();
        int st, cnt;
        clear_all();
        rd_base = 8'h40;
        send_seg(10'h052, 16'h0001, 8'd4, 1'b1);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        chk("R2", "read addr byte", addr_log[0], 8'hA5);
        chk("R5", "rx count", rx_n, 4);
        chk("R5", "rx0", rx_mem[0], 8'h40);
        chk("R5", "rx3", rx_mem[3], 8'h43);
        chk("R5", "ack byte2", mack_log[2], 0);
        chk("R5", "nak last", mack_log[3], 1);
        chk("R5", "status", st, 0);
        chk("R5", "count", cnt, 4);
    endtask

    task automatic t_chain();
        int st, cnt;
        clear_all();
        tx_arr[0] = 8'h5A; tx_arr[1] = 8'hA5;
        send_seg(10'h052, 16'h0000, 8'd2, 1'b0);
        wait_done(st, cnt);
        chk("R1", "seg1 status", st, 0);
        chk("R10", "no STOP after non-last", n_ev, 1);
        send_seg(10'h052, 16'h0001, 8'd2, 1'b1);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        chk("R1", "repeated START", ev_log[1], "S");
        chk("R10", "final STOP", ev_log[2], "P");
        chk("R10", "event total", n_ev, 3);
        chk("R1", "seg2 count", cnt, 2);
    endtask

    task automatic t_addr_nak();
        int st, cnt;
        clear_all();
        send_seg(10'h033, 16'h0000, 8'd2, 1'b0);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        chk("R6", "status", st, 1);
        chk("R6", "count", cnt, 0);
        chk("R6", "no data taken", take_n, 0);
        chk("R6", "STOP after NAK", ev_log[1], "P");
    endtask

    task automatic t_data_nak(input logic ign);
        int st, cnt;
        clear_all();
        nak_at = 2;
        tx_arr[0] = 8'h01; tx_arr[1] = 8'h02; tx_arr[2] = 8'h03; tx_arr[3] = 8'h04;
        send_seg(10'h052, ign ? 16'h1000 : 16'h0000, 8'd4, 1'b1);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        nak_at = 0;
        if (!ign) begin
            chk("R7", "status", st, 2);
            chk("R7", "count", cnt, 2);
            chk("R7", "target bytes", n_wr, 2);
            chk("R7", "STOP", ev_log[1], "P");
        end else begin
            chk("R8", "status", st, 0);
            chk("R8", "count", cnt, 4);
            chk("R8", "target bytes", n_wr, 4);
            chk("R8", "byte3", wr_log[3], 8'h04);
        end
    endtask

    task automatic t_ten();
        int st, cnt;
        clear_all();
        tx_arr[0] = 8'h77; tx_arr[1] = 8'h88;
        send_seg(SL10, 16'h0010, 8'd2, 1'b1);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        chk("R3", "first addr byte", addr_log[0], 8'hF4);
        chk("R3", "second addr byte", addr_log[1], 8'hA5);
        chk("R3", "status", st, 0);
        chk("R3", "data", wr_log[1], 8'h88);
        clear_all();
        rd_base = 8'h10;
        send_seg(SL10, 16'h0011, 8'd1, 1'b1);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        chk("R3", "read first addr byte", addr_log[0], 8'hF5);
        chk("R3", "read data", rx_mem[0], 8'h10);
    endtask

    task automatic t_rlen(input logic [7:0] lv, input int exp_more);
        int st, cnt;
        clear_all();
        len_en = 1'b1; len_val = lv; rd_base = 8'h80;
        send_seg(10'h052, 16'h0401, 8'd9, 1'b1);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        len_en = 1'b0;
        chk("R9", "count", cnt, exp_more + 1);
        chk("R9", "rx total", rx_n, exp_more + 1);
        chk("R9", "length byte delivered", rx_mem[0], lv);
        chk("R9", "length byte ACKed", mack_log[0], 0);
        chk("R9", "last byte NAK", mack_log[exp_more], 1);
        chk("R9", "last data", rx_mem[exp_more], 8'h80 + exp_more);
    endtask

    task automatic t_stretch();
        int st, cnt;
        stretch = 20;
        clear_all();
        tx_arr[0] = 8'hC3; tx_arr[1] = 8'h3C;
        send_seg(10'h052, 16'h0000, 8'd2, 1'b1);
        wait_done(st, cnt);
        repeat (4) @(negedge clk);
        stretch = 0;
        chk("R11", "stretched low seen", int'(low_max >= 20), 1);
        chk("R11", "status", st, 0);
        chk("R11", "data0", wr_log[0], 8'hC3);
        chk("R11", "data1", wr_log[1], 8'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write7();
        t_read7();
        t_chain();
        t_addr_nak();
        t_data_nak(1'b0);
        t_data_nak(1'b1);
        t_ten();
        t_rlen(8'd5, 5);
        t_rlen(8'd40, 32);
        t_stretch();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule